// File: doc/BRIEF.md
# Card Bus Access Cycle Sequencer

This block produces a single memory or I/O access on a 16-bit PC card style bus. The access is split into three timed phases. First comes setup, where the card enable, register select and address strobes are already valid but no command is active. Next comes command, where exactly one read or write command strobe is active. Last comes recovery, where the command is released but the card stays selected. Each phase length is programmed by an 8-bit timing byte. The byte holds a prescaler code and a multiplier value, and the phase lasts prescaler times value plus one clocks.

The host offers two timing sets of three bytes each and picks one per access with a select input. The selected set is captured when the access is launched, so the host may rewrite the timing inputs while an access runs. In normal mode a start pulse launches an access. In DMA mode the access is launched a fixed two clocks after DMA request and acknowledge are seen together. A card WAIT input can hold the command phase open past its programmed length. A one-clock done pulse closes each access.

Top module: `card_cycle_seq`

## Requirements
- R1: While rst_ni is low, and after its release until a launch, every strobe, busy_o and done_o are low.
- R2: A timing byte splits into a prescaler code in bits [7:6] and a value in bits [5:0]. Codes 0, 1, 2 and 3 select multipliers 1, 16, 256 and 4096. The phase length in clocks is multiplier × value + 1. For example, 01h gives 2, 06h gives 7, 03h gives 4, C0h gives 1, 41h gives 17 and 81h gives 257.
- R3: A start_i sampled high at a clock edge while idle raises card_en_o after that edge. The access then shows setup clocks with no command, command clocks, and recovery clocks with no command, in that order. card_en_o stays high through all three phases.
- R4: The command strobe depends on the type inputs sampled at launch, where is_io_i is 1 for I/O and is_write_i is 1 for write. Memory read gives mem_oe_o, memory write gives mem_we_o, I/O read gives io_rd_o and I/O write gives io_wr_o. reg_sel_o is high during I/O accesses and low during memory accesses.
- R5: done_o is high for exactly one clock. That clock directly follows the last recovery clock, and card_en_o is low during it.
- R6: A start_i that arrives while an access is running is ignored. No further access follows the running one.
- R7: The timing inputs are packed per set as setup in [7:0], command in [15:8] and recovery in [23:16]. set_sel_i = 0 selects tmr_set0_i and set_sel_i = 1 selects tmr_set1_i. The set select and the timing bytes are captured at launch, so changing them mid-access has no effect on that access.
- R8: The command phase stays active while card_wait_i is high once the programmed command count has run out. The command phase ends at the first clock edge that samples card_wait_i low. If WAIT is released before the count runs out, the command length is unchanged.
- R9: With dma_mode_i high, start_i is ignored and request alone does nothing. When dma_req_i and dma_ack_i are both sampled high at an edge while idle, card_en_o rises two edges later.
- R10: During a DMA access, io_rd_o, mem_oe_o and reg_sel_o are high for the whole access. io_wr_o is the command strobe and is active only in the command phase. mem_we_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request in normal mode |
| is_io_i | input | 1 | Access type: 1 = I/O, 0 = memory |
| is_write_i | input | 1 | Direction: 1 = write, 0 = read |
| set_sel_i | input | 1 | Timing set select |
| tmr_set0_i | input | 24 | Timing set 0: {recovery, command, setup} |
| tmr_set1_i | input | 24 | Timing set 1: {recovery, command, setup} |
| dma_mode_i | input | 1 | Launch from the DMA handshake instead of start_i |
| dma_req_i | input | 1 | DMA request |
| dma_ack_i | input | 1 | DMA acknowledge |
| card_wait_i | input | 1 | Card WAIT, active high |
| busy_o | output | 1 | Access running or DMA launch pending |
| card_en_o | output | 1 | Card enable / address valid for the whole access |
| reg_sel_o | output | 1 | Register space select |
| mem_oe_o | output | 1 | Memory read command |
| mem_we_o | output | 1 | Memory write command |
| io_rd_o | output | 1 | I/O read command |
| io_wr_o | output | 1 | I/O write command |
| done_o | output | 1 | One-clock end-of-access pulse |

## Verification
A start_i sampled at one edge shows card_en_o right after that edge. A DMA handshake sampled at one edge shows card_en_o after the second edge that follows. done_o appears one clock after the last recovery clock. A WAIT release takes effect at the very next edge once the command count has run out. The bench drives inputs just after rising edges and samples all outputs at falling edges. It counts setup, command and recovery clocks one falling edge at a time, so every expected count is a whole number of clocks. The counts are set by the phase formula, the WAIT release point or the fixed DMA delay.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  localparam int PRES_W    = 2;
  localparam int VAL_W     = 6;
  localparam int REG_W     = PRES_W + VAL_W;
  localparam int PHASES    = 3;
  localparam int SET_W     = PHASES * REG_W;
  localparam int PRES_SHIFT = 4;
  localparam int MAX_PRES  = (1 << PRES_W) - 1;
  localparam int MAX_LEN   = (1 << (PRES_SHIFT * MAX_PRES)) * ((1 << VAL_W) - 1) + 1;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int SH_W      = $clog2(PRES_SHIFT * MAX_PRES + 1);

  localparam int PH_SETUP = 0;
  localparam int PH_CMD   = 1;
  localparam int PH_REC   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CMD   = 2'd2,
    ST_REC   = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic io;
    logic wr;
    logic dma;
  } cyc_kind_t;
endpackage

// File: rtl/card_phase_len.sv
module card_phase_len
  import card_seq_pkg::*;
(
  input  logic [REG_W-1:0] tmr_i,
  output logic [CNT_W-1:0] len_o
);
  logic [CNT_W-1:0] val_ext;
  logic [SH_W-1:0]  sh;

  assign val_ext = CNT_W'(tmr_i[VAL_W-1:0]);
  // prescaler multiplies by 16^code
  assign sh      = SH_W'(tmr_i[REG_W-1 -: PRES_W]) * SH_W'(PRES_SHIFT);
  assign len_o   = (val_ext << sh) + CNT_W'(1);
endmodule

// File: rtl/card_dma_gate.sv
module card_dma_gate #(
  parameter int DLY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_i,
  input  logic ack_i,
  output logic launch_o,
  output logic pend_o
);
  logic [DLY-1:0] pipe_q;
  logic           fire;

  assign fire     = en_i & req_i & ack_i & ~(|pipe_q);
  assign launch_o = pipe_q[DLY-1];
  assign pend_o   = |pipe_q;

  generate
    if (DLY == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= fire;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[DLY-2:0], fire};
      end
    end
  endgenerate
endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
  import card_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic [CNT_W-1:0] len_setup_i,
  input  logic [CNT_W-1:0] len_cmd_i,
  input  logic [CNT_W-1:0] len_rec_i,
  input  logic             wait_i,
  output seq_state_e       state_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (launch_i) begin
            state_q <= ST_SETUP;
            cnt_q   <= len_setup_i - CNT_W'(1);
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state_q <= ST_CMD;
            cnt_q   <= len_cmd_i - CNT_W'(1);
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_CMD: begin
          if (cnt_zero) begin
            // card WAIT holds the strobe once the count has run out
            if (!wait_i) begin
              state_q <= ST_REC;
              cnt_q   <= len_rec_i - CNT_W'(1);
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_REC: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/card_cycle_seq.sv
module card_cycle_seq
  import card_seq_pkg::*;
#(
  parameter int DMA_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             is_io_i,
  input  logic             is_write_i,
  input  logic             set_sel_i,
  input  logic [SET_W-1:0] tmr_set0_i,
  input  logic [SET_W-1:0] tmr_set1_i,
  input  logic             dma_mode_i,
  input  logic             dma_req_i,
  input  logic             dma_ack_i,
  input  logic             card_wait_i,
  output logic             busy_o,
  output logic             card_en_o,
  output logic             reg_sel_o,
  output logic             mem_oe_o,
  output logic             mem_we_o,
  output logic             io_rd_o,
  output logic             io_wr_o,
  output logic             done_o
);
  seq_state_e       state;
  logic             fsm_idle, launch, gate_launch, gate_pend;
  logic             active, in_cmd;
  logic [SET_W-1:0] tmr_live, tmr_q, tmr_use;
  cyc_kind_t        kind_q;
  logic [CNT_W-1:0] len [PHASES];

  assign fsm_idle = (state == ST_IDLE);
  assign tmr_live = set_sel_i ? tmr_set1_i : tmr_set0_i;
  // live set feeds the setup load at launch; captured set afterwards
  assign tmr_use  = fsm_idle ? tmr_live : tmr_q;
  assign launch   = fsm_idle & (dma_mode_i ? gate_launch : start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      kind_q <= '0;
    end else if (launch) begin
      tmr_q  <= tmr_live;
      kind_q <= '{io: is_io_i, wr: is_write_i, dma: dma_mode_i};
    end
  end

  card_dma_gate #(.DLY(DMA_DLY)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (fsm_idle & dma_mode_i),
    .req_i   (dma_req_i),
    .ack_i   (dma_ack_i),
    .launch_o(gate_launch),
    .pend_o  (gate_pend)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_len
    card_phase_len u_len (
      .tmr_i(tmr_use[p*REG_W +: REG_W]),
      .len_o(len[p])
    );
  end

  card_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .launch_i   (launch),
    .len_setup_i(len[PH_SETUP]),
    .len_cmd_i  (len[PH_CMD]),
    .len_rec_i  (len[PH_REC]),
    .wait_i     (card_wait_i),
    .state_o    (state),
    .done_o     (done_o)
  );

  assign active    = ~fsm_idle;
  assign in_cmd    = (state == ST_CMD);
  assign busy_o    = active | gate_pend;
  assign card_en_o = active;

  always_comb begin
    reg_sel_o = 1'b0;
    mem_oe_o  = 1'b0;
    mem_we_o  = 1'b0;
    io_rd_o   = 1'b0;
    io_wr_o   = 1'b0;
    if (kind_q.dma) begin
      reg_sel_o = active;
      mem_oe_o  = active;
      io_rd_o   = active;
      io_wr_o   = in_cmd;
    end else begin
      reg_sel_o = active & kind_q.io;
      mem_oe_o  = in_cmd & ~kind_q.io & ~kind_q.wr;
      mem_we_o  = in_cmd & ~kind_q.io &  kind_q.wr;
      io_rd_o   = in_cmd &  kind_q.io & ~kind_q.wr;
      io_wr_o   = in_cmd &  kind_q.io &  kind_q.wr;
    end
  end
endmodule

// File: rtl/card_seq_chk.sv
module card_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic card_en_i,
  input logic done_i,
  input logic mem_oe_i,
  input logic mem_we_i,
  input logic io_rd_i,
  input logic io_wr_i,
  input logic in_cmd_i,
  input logic wait_i
);
  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R5
  done_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $fell(card_en_i));

  // R3
  cmd_inside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_oe_i | mem_we_i | io_rd_i | io_wr_i) |-> card_en_i);

  // R3
  setup_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_en_i) |-> !in_cmd_i && !mem_we_i && !io_wr_i);

  // R8
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_cmd_i && wait_i) |=> in_cmd_i);

  // R4
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_i, mem_oe_i}) && !(mem_we_i && io_wr_i));
endmodule

bind card_cycle_seq card_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .card_en_i(card_en_o),
  .done_i   (done_o),
  .mem_oe_i (mem_oe_o),
  .mem_we_i (mem_we_o),
  .io_rd_i  (io_rd_o),
  .io_wr_i  (io_wr_o),
  .in_cmd_i (in_cmd),
  .wait_i   (card_wait_i)
);

// File: tb/sim_card_cycle_seq.sv
`timescale 1ns/1ps
module sim_card_cycle_seq;
  localparam int CLK_PERIOD = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, is_io = 1'b0, is_wr = 1'b0, set_sel = 1'b0;
  logic [23:0] tset0 = 24'h030601, tset1 = 24'h0241C0;
  logic        dma_mode = 1'b0, dma_req = 1'b0, dma_ack = 1'b0, wait_c = 1'b0;
  logic        busy, card_en, reg_sel, mem_oe, mem_we, io_rd, io_wr, done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_cycle_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .is_io_i(is_io),
    .is_write_i(is_wr), .set_sel_i(set_sel), .tmr_set0_i(tset0),
    .tmr_set1_i(tset1), .dma_mode_i(dma_mode), .dma_req_i(dma_req),
    .dma_ack_i(dma_ack), .card_wait_i(wait_c), .busy_o(busy),
    .card_en_o(card_en), .reg_sel_o(reg_sel), .mem_oe_o(mem_oe),
    .mem_we_o(mem_we), .io_rd_o(io_rd), .io_wr_o(io_wr), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  // seen = {reg_sel, io_wr, io_rd, mem_we, mem_oe} ORed over command clocks
  task automatic measure(input bit dma, input int wait_drop,
                         output int s, output int c, output int r,
                         output logic [4:0] seen, output bit ok);
    int  phase = 0;
    bit  cmd_now;
    s = 0; c = 0; r = 0; seen = '0; ok = 1'b1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done) begin
        if (card_en) ok = 1'b0;
        break;
      end
      if (!card_en) begin ok = 1'b0; continue; end
      if (dma && !(io_rd && mem_oe && reg_sel)) ok = 1'b0;
      cmd_now = dma ? io_wr : (mem_oe | mem_we | io_rd | io_wr);
      if (cmd_now) begin
        if (phase == 2) ok = 1'b0;
        phase = 1; c++;
        seen |= {reg_sel, io_wr, io_rd, mem_we, mem_oe};
        if (wait_drop > 0 && c == 1) wait_c = 1'b1;
        if (c == wait_drop) wait_c = 1'b0;
      end else if (phase == 0) s++;
      else begin phase = 2; r++; end
    end
    @(negedge clk);
    if (done) ok = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({busy, card_en, reg_sel, mem_oe, mem_we, io_rd, io_wr, done} == 0, "R1 in reset", 1, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, card_en, reg_sel, mem_oe, mem_we, io_rd, io_wr, done} == 0, "R1 after reset", 1, 0);
  endtask

  task automatic t_default();
    int s, c, r; logic [4:0] sn; bit ok;
    set_sel = 0; is_io = 0; is_wr = 0;
    pulse_start();
    measure(0, 0, s, c, r, sn, ok);
    chk(s == 2, "R2 R3 setup 01h", s, 2);
    chk(c == 7, "R2 R3 command 06h", c, 7);
    chk(r == 4, "R2 R3 recovery 03h", r, 4);
    chk(ok, "R5 done pulse and phase order", ok, 1);
    chk(sn == 5'b00001, "R4 memory read strobe", sn, 5'b00001);
  endtask

  task automatic t_types();
    int s, c, r; logic [4:0] sn; bit ok;
    logic [4:0] exp [4] = '{5'b00001, 5'b00010, 5'b10100, 5'b11000};
    tset0 = 24'h000000;
    for (int t = 0; t < 4; t++) begin
      is_io = t[1]; is_wr = t[0];
      pulse_start();
      measure(0, 0, s, c, r, sn, ok);
      chk(sn == exp[t], "R4 type strobe", sn, exp[t]);
      chk(s == 1 && c == 1 && r == 1 && ok, "R2 minimum lengths", s*100 + c*10 + r, 111);
    end
    tset0 = 24'h030601; is_io = 0; is_wr = 0;
  endtask

  task automatic t_prescale();
    int s, c, r; logic [4:0] sn; bit ok;
    set_sel = 1;
    pulse_start();
    measure(0, 0, s, c, r, sn, ok);
    chk(s == 1, "R2 R7 set1 setup C0h", s, 1);
    chk(c == 17, "R2 R7 set1 command 41h", c, 17);
    chk(r == 3 && ok, "R2 R7 set1 recovery 02h", r, 3);
    tset1 = 24'h10813F;
    pulse_start();
    measure(0, 0, s, c, r, sn, ok);
    chk(s == 64, "R2 setup 3Fh", s, 64);
    chk(c == 257, "R2 command 81h", c, 257);
    chk(r == 17 && ok, "R2 recovery 10h", r, 17);
    tset1 = 24'h0241C0; set_sel = 0;
  endtask

  task automatic t_latch();
    int s, c, r; logic [4:0] sn; bit ok;
    set_sel = 0;
    pulse_start();
    set_sel = 1; tset0 = 24'h000000;
    measure(0, 0, s, c, r, sn, ok);
    chk(s == 2 && c == 7 && r == 4 && ok, "R7 captured at launch", s*100 + c*10 + r, 274);
    set_sel = 0; tset0 = 24'h030601;
  endtask

  task automatic t_busy();
    int s, c, r; logic [4:0] sn; bit ok; bit extra = 0;
    pulse_start();
    fork
      measure(0, 0, s, c, r, sn, ok);
      begin
        repeat (3) @(negedge clk);
        start = 1'b1;
        repeat (4) @(posedge clk);
        #1 start = 1'b0;
      end
    join
    chk(s == 2 && c == 7 && r == 4 && ok, "R6 running access unchanged", s*100 + c*10 + r, 274);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (card_en || busy) extra = 1;
    end
    chk(!extra, "R6 no access after busy start", extra, 0);
  endtask

  task automatic t_wait();
    int s, c, r; logic [4:0] sn; bit ok;
    pulse_start();
    measure(0, 10, s, c, r, sn, ok);
    chk(c == 10, "R8 WAIT extends command", c, 10);
    chk(s == 2 && r == 4 && ok, "R8 other phases unchanged", s*10 + r, 24);
    pulse_start();
    measure(0, 3, s, c, r, sn, ok);
    chk(c == 7 && ok, "R8 early WAIT release", c, 7);
  endtask

  task automatic t_dma();
    int s, c, r; logic [4:0] sn; bit ok; bit early = 0;
    dma_mode = 1;
    pulse_start();
    dma_req = 1;
    repeat (4) begin
      @(negedge clk);
      if (card_en || busy) early = 1;
    end
    chk(!early, "R9 start and lone request ignored", early, 0);
    dma_ack = 1;
    @(negedge clk); if (card_en) early = 1;
    @(negedge clk); if (card_en) early = 1;
    dma_req = 0; dma_ack = 0;
    chk(!early, "R9 no access before two edges", early, 0);
    measure(1, 0, s, c, r, sn, ok);
    chk(s == 2, "R9 card enable on second edge", s, 2);
    chk(c == 7 && r == 4, "R10 DMA phase lengths", c*10 + r, 74);
    chk(ok, "R10 read and enable held all access", ok, 1);
    chk(sn == 5'b11101, "R10 DMA strobe set", sn, 5'b11101);
    dma_mode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_default();
    t_types();
    t_prescale();
    t_latch();
    t_busy();
    t_wait();
    t_dma();
    summary();
    $finish;
  end
endmodule